// File: doc/BRIEF.md
# Bit-Interleaving Twin Flash Datapath

This block sits between a flash command sequencer and a pair of serial flash devices that are wired side by side so that every logical byte lives in both of them at once. For memory-array reads and programs, each byte is torn into two 4-bit halves. The half built from the even-numbered bits goes to the low device and the half built from the odd-numbered bits goes to the high device. On the way back, the two halves are woven together into one byte again. Register commands (status, ID, configuration and so on) must reach both devices unchanged, so for those the block copies each byte onto both lanes instead of splitting it.

A command arrives as one beat holding the opcode, the logical address, a data length and a direction. The opcode is checked against a parameter list of split opcodes when the command is accepted, which is before any data moves. Both chip selects drop together on the cycle after the command is accepted. Next comes the opcode beat, then the address beats for split commands only, then the data beats. Both chip selects rise together once the last data beat has been transferred. Shifting on the serial pins is modelled as lane-pair streams (`tx_*`, `rx_*`) and is not part of this block.

Every stream uses valid/ready handshakes, and a beat moves on a cycle where valid and ready are both high. After a source raises valid, it must hold valid and its data steady until the beat is taken. During a write data phase, `wr_ready` follows `tx_ready`, so device back-pressure passes straight through to the writer. During a read data phase, `rx_ready` follows `rd_ready`, so a stalled reader holds off the devices.

Top module: `twin_flash_interleaver`

## Requirements
- R1: The first `tx` beat after a command is accepted carries the opcode on both lanes (`tx_lo` = `tx_hi` = opcode) with `tx_nib` = 0.
- R2: A split command sends `ADDR_BYTES` address beats after the opcode, most significant byte first. Their value is the logical address shifted right by one, and both lanes carry the same value with `tx_nib` = 0. A broadcast command sends no address beats.
- R3: In a split write, data bit 2k appears on `tx_lo[k]` and data bit 2k+1 appears on `tx_hi[k]` for k = 0..3. `tx_lo[7:4]` and `tx_hi[7:4]` are zero, and `tx_nib` = 1.
- R4: In a split read, bit 2k of `rd_data` is `rx_lo[k]` and bit 2k+1 is `rx_hi[k]`.
- R5: In a broadcast write, each data byte appears unchanged on both lanes with `tx_nib` = 0.
- R6: A broadcast read returns `rx_lo`. A beat whose `rx_lo` differs from `rx_hi` sets `mm_flag`, and `mm_flag` stays set until reset.
- R7: `cs_lo_n` and `cs_hi_n` always have the same value. Both are low from the cycle after a command is accepted until the last beat of that command has been transferred.
- R8: `cmd_ready` is high only when no command is active. A `tx` beat that is not taken holds its lane values until it is taken.
- R9: Exactly `cmd_len` data beats are transferred. With `cmd_len` = 0 the command ends after its header.
- R10: After reset, the chip selects are high, `cmd_ready` is high, `tx_valid` and `rd_valid` are low, and `mm_flag` is low.
- R11: Only opcodes listed in `SPLIT_OPS` are split (defaults 0x03, 0x0B, 0x02, 0x32). Every other opcode is broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command beat valid |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_opcode | input | 8 | Flash opcode |
| cmd_addr | input | ADDR_W | Logical byte address |
| cmd_len | input | LEN_W | Number of data bytes |
| cmd_write | input | 1 | 1 = data flows to the devices |
| wr_valid | input | 1 | Write byte valid |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Logical write byte |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | Reader can take a byte |
| rd_data | output | 8 | Logical read byte |
| tx_valid | output | 1 | Lane-pair beat to devices valid |
| tx_ready | input | 1 | Devices take the beat |
| tx_lo | output | 8 | Beat for the low device |
| tx_hi | output | 8 | Beat for the high device |
| tx_nib | output | 1 | 1 = only bits [3:0] of each lane are meaningful |
| rx_valid | input | 1 | Lane-pair beat from devices valid |
| rx_ready | output | 1 | Beat from devices taken |
| rx_lo | input | 8 | Beat from the low device |
| rx_hi | input | 8 | Beat from the high device |
| cs_lo_n | output | 1 | Low device select, active low |
| cs_hi_n | output | 1 | High device select, active low |
| mm_flag | output | 1 | Sticky register-read mismatch |

## Verification
A wrongly latched split/broadcast decision shows up within the first one to four `tx` beats. Either the address beats appear or vanish right after the opcode, or `tx_nib` and the lane contents are wrong on the first data beat. A corrupted byte counter or state register shows up as a chip select that rises early or late, which can be seen as a wrong beat count by the time the chip selects return high. A fault in the bit-lane mapping shows on the very data beat concerned, on `tx_lo`/`tx_hi` or on `rd_data`. The sticky mismatch flag is checked the cycle after the differing beat and again after a later clean read.

// File: rtl/twf_pkg.sv
package twf_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA
  } twf_state_e;

  typedef struct packed {
    logic [BYTE_W-1:0] lo;
    logic [BYTE_W-1:0] hi;
    logic              nib;
  } twf_beat_t;
endpackage

// File: rtl/twf_op_decode.sv
module twf_op_decode #(
  parameter int NUM_OPS = 4,
  parameter logic [NUM_OPS*8-1:0] OP_LIST = {8'h32, 8'h02, 8'h0B, 8'h03}
) (
  input  logic [7:0] opcode,
  output logic       split
);
  logic [NUM_OPS-1:0] hit;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_cmp
    assign hit[g] = (opcode == OP_LIST[g*8 +: 8]);
  end

  assign split = |hit;
endmodule

// File: rtl/twf_splitter.sv
module twf_splitter
  import twf_pkg::*;
(
  input  logic [BYTE_W-1:0] data,
  input  logic              split,
  output twf_beat_t         beat
);
  logic [NIB_W-1:0] even_bits;
  logic [NIB_W-1:0] odd_bits;

  for (genvar g = 0; g < NIB_W; g++) begin : g_pick
    assign even_bits[g] = data[2*g];
    assign odd_bits[g]  = data[2*g+1];
  end

  always_comb begin
    if (split) begin
      beat.lo  = {{NIB_W{1'b0}}, even_bits};
      beat.hi  = {{NIB_W{1'b0}}, odd_bits};
      beat.nib = 1'b1;
    end else begin
      beat.lo  = data;
      beat.hi  = data;
      beat.nib = 1'b0;
    end
  end
endmodule

// File: rtl/twf_merger.sv
module twf_merger
  import twf_pkg::*;
(
  input  logic [BYTE_W-1:0] lane_lo,
  input  logic [BYTE_W-1:0] lane_hi,
  input  logic              split,
  output logic [BYTE_W-1:0] data,
  output logic              differ
);
  logic [BYTE_W-1:0] woven;

  for (genvar g = 0; g < NIB_W; g++) begin : g_weave
    assign woven[2*g]   = lane_lo[g];
    assign woven[2*g+1] = lane_hi[g];
  end

  assign data   = split ? woven : lane_lo;
  assign differ = !split && (lane_lo != lane_hi);
endmodule

// File: rtl/twin_flash_interleaver.sv
module twin_flash_interleaver
  import twf_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int LEN_W      = 8,
  parameter int NUM_SPLIT  = 4,
  parameter logic [NUM_SPLIT*8-1:0] SPLIT_OPS = {8'h32, 8'h02, 8'h0B, 8'h03},
  localparam int ADDR_W    = 8 * ADDR_BYTES + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_opcode,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              cmd_write,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_lo,
  output logic [7:0]        tx_hi,
  output logic              tx_nib,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_lo,
  input  logic [7:0]        rx_hi,
  output logic              cs_lo_n,
  output logic              cs_hi_n,
  output logic              mm_flag
);
  localparam int DEV_AW = 8 * ADDR_BYTES;
  localparam int HCNT_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [HCNT_W-1:0] HCNT_LAST = HCNT_W'(ADDR_BYTES - 1);

  twf_state_e        state_q, state_d;
  logic [7:0]        op_q;
  logic [DEV_AW-1:0] addr_sr_q;
  logic [LEN_W-1:0]  len_q, dcnt_q, dcnt_nx;
  logic [HCNT_W-1:0] hcnt_q;
  logic              wr_q, split_q, dec_split;
  logic              cs_lo_q, cs_hi_q, mm_q;
  logic              accept, hdr_hs, data_hs, last_data, merge_differ;
  twf_beat_t         split_beat, beat;

  twf_op_decode #(.NUM_OPS(NUM_SPLIT), .OP_LIST(SPLIT_OPS)) u_decode (
    .opcode (cmd_opcode),
    .split  (dec_split)
  );

  twf_splitter u_split (
    .data  (wr_data),
    .split (split_q),
    .beat  (split_beat)
  );

  twf_merger u_merge (
    .lane_lo (rx_lo),
    .lane_hi (rx_hi),
    .split   (split_q),
    .data    (rd_data),
    .differ  (merge_differ)
  );

  assign accept    = (state_q == ST_IDLE) && cmd_valid;
  assign dcnt_nx   = dcnt_q + LEN_W'(1);
  assign last_data = (dcnt_nx == len_q);

  always_comb begin
    state_d   = state_q;
    cmd_ready = 1'b0;
    tx_valid  = 1'b0;
    wr_ready  = 1'b0;
    rx_ready  = 1'b0;
    rd_valid  = 1'b0;
    hdr_hs    = 1'b0;
    data_hs   = 1'b0;
    beat      = '{lo: op_q, hi: op_q, nib: 1'b0};
    unique case (state_q)
      ST_IDLE: begin
        cmd_ready = 1'b1;
        if (cmd_valid) state_d = ST_OPC;
      end
      ST_OPC: begin
        tx_valid = 1'b1;
        if (tx_ready) begin
          if (split_q)            state_d = ST_ADDR;
          else if (len_q == '0)   state_d = ST_IDLE;
          else                    state_d = ST_DATA;
        end
      end
      ST_ADDR: begin
        tx_valid = 1'b1;
        beat     = '{lo: addr_sr_q[DEV_AW-1 -: 8], hi: addr_sr_q[DEV_AW-1 -: 8], nib: 1'b0};
        hdr_hs   = tx_ready;
        if (tx_ready && hcnt_q == HCNT_LAST)
          state_d = (len_q == '0) ? ST_IDLE : ST_DATA;
      end
      ST_DATA: begin
        if (wr_q) begin
          tx_valid = wr_valid;
          wr_ready = tx_ready;
          beat     = split_beat;
          data_hs  = wr_valid && tx_ready;
        end else begin
          rd_valid = rx_valid;
          rx_ready = rd_ready;
          data_hs  = rx_valid && rd_ready;
        end
        if (data_hs && last_data) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign tx_lo  = beat.lo;
  assign tx_hi  = beat.hi;
  assign tx_nib = beat.nib;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      op_q      <= '0;
      addr_sr_q <= '0;
      len_q     <= '0;
      dcnt_q    <= '0;
      hcnt_q    <= '0;
      wr_q      <= 1'b0;
      split_q   <= 1'b0;
      cs_lo_q   <= 1'b1;
      cs_hi_q   <= 1'b1;
      mm_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      cs_lo_q <= (state_d == ST_IDLE);
      cs_hi_q <= (state_d == ST_IDLE);
      if (accept) begin
        op_q      <= cmd_opcode;
        addr_sr_q <= cmd_addr[ADDR_W-1:1];
        len_q     <= cmd_len;
        wr_q      <= cmd_write;
        split_q   <= dec_split;
        hcnt_q    <= '0;
        dcnt_q    <= '0;
      end
      if (hdr_hs) begin
        addr_sr_q <= addr_sr_q << 8;
        hcnt_q    <= hcnt_q + HCNT_W'(1);
      end
      if (data_hs) dcnt_q <= dcnt_nx;
      if (data_hs && !wr_q && merge_differ) mm_q <= 1'b1;
    end
  end

  assign cs_lo_n = cs_lo_q;
  assign cs_hi_n = cs_hi_q;
  assign mm_flag = mm_q;
endmodule

// File: rtl/twin_flash_interleaver_chk.sv
module twin_flash_interleaver_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_lo_n,
  input logic       cs_hi_n,
  input logic       cmd_ready,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_lo,
  input logic [7:0] tx_hi,
  input logic       tx_nib,
  input logic       rd_valid,
  input logic       mm_flag
);
  assert_cs_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_lo_n == cs_hi_n);

  assert_idle_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (cs_lo_n && !tx_valid && !rd_valid));

  assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_lo) && $stable(tx_hi) && $stable(tx_nib)));

  assert_nib_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_nib) |-> (tx_lo[7:4] == 4'h0 && tx_hi[7:4] == 4'h0));

  assert_mm_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mm_flag |=> mm_flag);

  assert_rd_selected_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !cs_lo_n);
endmodule

bind twin_flash_interleaver twin_flash_interleaver_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_lo_n   (cs_lo_n),
  .cs_hi_n   (cs_hi_n),
  .cmd_ready (cmd_ready),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_lo     (tx_lo),
  .tx_hi     (tx_hi),
  .tx_nib    (tx_nib),
  .rd_valid  (rd_valid),
  .mm_flag   (mm_flag)
);

// File: tb/twin_flash_interleaver_bench.sv
module twin_flash_interleaver_bench;
  localparam int ADDR_W = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cmd_valid = 0, cmd_ready, cmd_write = 0;
  logic [7:0] cmd_opcode = 0;
  logic [ADDR_W-1:0] cmd_addr = 0;
  logic [7:0] cmd_len = 0;
  logic wr_valid = 1, wr_ready;
  logic [7:0] wr_data = 0;
  logic rd_valid, rd_ready = 1;
  logic [7:0] rd_data;
  logic tx_valid, tx_ready = 1, tx_nib;
  logic [7:0] tx_lo, tx_hi;
  logic rx_valid = 1, rx_ready;
  logic [7:0] rx_lo = 0, rx_hi = 0;
  logic cs_lo_n, cs_hi_n, mm_flag;

  twin_flash_interleaver u_twin_flash_interleaver (.*);

  // data, even-bit nibble, odd-bit nibble
  localparam logic [15:0] VEC [8] = '{
    {8'hA5, 4'h3, 4'hC}, {8'hFF, 4'hF, 4'hF}, {8'h00, 4'h0, 4'h0},
    {8'h55, 4'hF, 4'h0}, {8'hAA, 4'h0, 4'hF}, {8'h0F, 4'h3, 4'h3},
    {8'hF0, 4'hC, 4'hC}, {8'h96, 4'h6, 4'h9}};

  int n_chk = 0, n_bad = 0;
  logic bp_en = 0, mon_clr = 0, cs_seen = 0;
  logic [7:0] wr_buf [16];
  logic [7:0] rxl_buf [16];
  logic [7:0] rxh_buf [16];
  logic [7:0] txl [16];
  logic [7:0] txh [16];
  logic       txn [16];
  logic [7:0] rdb [16];
  int tx_n = 0, rd_n = 0, wr_idx = 0, rx_idx = 0;

  always @(posedge clk) begin
    if (mon_clr) begin
      tx_n <= 0; rd_n <= 0; wr_idx <= 0; rx_idx <= 0; cs_seen <= 0;
    end else begin
      if (!cs_lo_n) cs_seen <= 1;
      if (tx_valid && tx_ready && tx_n < 16) begin
        txl[tx_n] <= tx_lo; txh[tx_n] <= tx_hi; txn[tx_n] <= tx_nib; tx_n <= tx_n + 1;
      end
      if (rd_valid && rd_ready && rd_n < 16) begin
        rdb[rd_n] <= rd_data; rd_n <= rd_n + 1;
      end
      if (wr_valid && wr_ready) wr_idx <= wr_idx + 1;
      if (rx_valid && rx_ready) rx_idx <= rx_idx + 1;
    end
  end

  always @(negedge clk) begin
    wr_data  <= wr_buf[wr_idx % 16];
    rx_lo    <= rxl_buf[rx_idx % 16];
    rx_hi    <= rxh_buf[rx_idx % 16];
    tx_ready <= bp_en ? ~tx_ready : 1'b1;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [7:0] op, input logic [ADDR_W-1:0] a,
                         input int len, input logic wr);
    @(negedge clk); mon_clr = 1;
    @(negedge clk); mon_clr = 0;
    cmd_valid = 1; cmd_opcode = op; cmd_addr = a; cmd_len = 8'(len); cmd_write = wr;
    @(negedge clk); cmd_valid = 0;
    check(!cmd_ready, "R8 busy", int'(cmd_ready), 0);
    for (int i = 0; i < 100; i++) begin
      if (cs_lo_n) break;
      @(negedge clk);
    end
    check(cs_seen && cs_lo_n && cs_hi_n, "R7 select window", int'(cs_seen), 1);
  endtask

  task automatic check_hdr(input logic [7:0] op, input logic [ADDR_W-1:0] a, input logic split);
    logic [23:0] dev;
    dev = a[ADDR_W-1:1];
    check(txl[0] == op && txh[0] == op && !txn[0], "R1 opcode beat", int'(txl[0]), int'(op));
    if (split)
      for (int k = 0; k < 3; k++)
        check(txl[1+k] == dev[23-8*k -: 8] && txh[1+k] == dev[23-8*k -: 8] && !txn[1+k],
              "R2 address beat", int'(txl[1+k]), int'(dev[23-8*k -: 8]));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cs_lo_n && cs_hi_n && cmd_ready && !tx_valid && !rd_valid && !mm_flag,
          "R10 reset state", int'({cs_lo_n, cs_hi_n, cmd_ready, tx_valid, rd_valid, mm_flag}), 'h38);
    rst_n = 1;
    @(negedge clk);

    // table walk: split write then split read per vector (R3, R4, R11)
    for (int v = 0; v < 8; v++) begin
      logic [ADDR_W-1:0] a;
      a = 25'h1ABCDE + 25'(2 * v);
      wr_buf[0] = VEC[v][15:8];
      run_cmd(8'h02, a, 1, 1'b1);
      check(tx_n == 5, "R9 split write beat count", tx_n, 5);
      check_hdr(8'h02, a, 1'b1);
      check(txl[4] == {4'h0, VEC[v][7:4]} && txh[4] == {4'h0, VEC[v][3:0]} && txn[4],
            "R3 split lanes", int'({txl[4], txh[4]}), int'({4'h0, VEC[v][7:4], 4'h0, VEC[v][3:0]}));
      rxl_buf[0] = {4'h0, VEC[v][7:4]};
      rxh_buf[0] = {4'h0, VEC[v][3:0]};
      run_cmd(8'h0B, a, 1, 1'b0);
      check(tx_n == 4 && rd_n == 1, "R2 split read header", tx_n, 4);
      check(rdb[0] == VEC[v][15:8], "R4 merge", int'(rdb[0]), int'(VEC[v][15:8]));
    end

    // broadcast write, register opcode: no address, identical lanes (R5, R11)
    wr_buf[0] = 8'h3C; wr_buf[1] = 8'hC5;
    run_cmd(8'h01, 25'h0000AB, 2, 1'b1);
    check(tx_n == 3, "R2 no address on broadcast", tx_n, 3);
    check_hdr(8'h01, 25'h0, 1'b0);
    check(txl[1] == 8'h3C && txh[1] == 8'h3C && !txn[1], "R5 broadcast byte0", int'(txh[1]), 'h3C);
    check(txl[2] == 8'hC5 && txh[2] == 8'hC5 && !txn[2], "R5 broadcast byte1", int'(txh[2]), 'hC5);

    // zero length split read (R9)
    run_cmd(8'h03, 25'h000010, 0, 1'b0);
    check(tx_n == 4 && rd_n == 0, "R9 zero length", rd_n, 0);

    // matching register read leaves flag clear (R6, R11)
    rxl_buf[0] = 8'h9D; rxh_buf[0] = 8'h9D;
    run_cmd(8'h9F, 25'h0, 1, 1'b0);
    check(rd_n == 1 && rdb[0] == 8'h9D, "R6 broadcast read", int'(rdb[0]), 'h9D);
    check(!mm_flag, "R6 no mismatch", int'(mm_flag), 0);

    // mismatching register read sets flag, low lane returned
    rxl_buf[0] = 8'h12; rxh_buf[0] = 8'h12; rxl_buf[1] = 8'h34; rxh_buf[1] = 8'h35;
    run_cmd(8'h05, 25'h0, 2, 1'b0);
    check(rdb[0] == 8'h12 && rdb[1] == 8'h34, "R6 low lane returned", int'(rdb[1]), 'h34);
    check(mm_flag, "R6 mismatch set", int'(mm_flag), 1);
    rxl_buf[0] = 8'h77; rxh_buf[0] = 8'h77;
    run_cmd(8'h05, 25'h0, 1, 1'b0);
    check(mm_flag, "R6 mismatch sticky", int'(mm_flag), 1);

    // back-pressure on tx during split write (R8, R3)
    bp_en = 1;
    wr_buf[0] = 8'hA5; wr_buf[1] = 8'h96; wr_buf[2] = 8'h0F;
    run_cmd(8'h32, 25'h000400, 3, 1'b1);
    bp_en = 0;
    check(tx_n == 7, "R8 stalled beat count", tx_n, 7);
    check_hdr(8'h32, 25'h000400, 1'b1);
    check(txl[4] == 8'h03 && txh[4] == 8'h0C, "R8 stalled byte0", int'(txl[4]), 3);
    check(txl[5] == 8'h06 && txh[5] == 8'h09, "R8 stalled byte1", int'(txl[5]), 6);
    check(txl[6] == 8'h03 && txh[6] == 8'h03, "R8 stalled byte2", int'(txl[6]), 3);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule